// File: doc/BRIEF.md
# Key-Armed Watchdog Timer with Reset Pulse

This block is a watchdog timer that stays asleep after every reset. Software wakes it by writing two fixed key bytes, in order, to a write-only port. From then on a 14-bit counter advances once per machine-cycle enable. Repeating the same two-byte key restarts the count from zero. No path exists to switch the watchdog off again, other than a chip reset or the watchdog's own expiry.

When the counter runs past its top value, the block drives a reset pulse that lasts a fixed number of oscillator clocks. At the end of the pulse the block disarms itself and clears its counter, so software has to arm it again. A disable input hides the pulse from the output pin but leaves the internal timing unchanged.

Counting pauses during power-down. After power-down is left through a wake interrupt, counting stays paused until the interrupt line returns high. In idle the counter keeps running by default. An option input makes it hold its value in idle instead, and it resumes once idle ends.

Top module: `seq_watchdog`

## Requirements
- R1: After reset `armed_o` and `rst_pulse_o` are 0, and machine-cycle enables cause no expiry until the watchdog is armed.
- R2: A write of 0x1E followed by a write of 0xE1 arms the watchdog, and `armed_o` is 1 from the cycle after the 0xE1 write. Cycles without writes may separate the two bytes.
- R3: A byte other than 0xE1 written right after 0x1E, or a 0xE1 not preceded by 0x1E, abandons the sequence and neither arms nor clears. A new 0x1E always starts a fresh sequence.
- R4: While armed and free to run, the counter advances once per clock with `tick_i` high. Expiry happens on the tick that finds the count at 0x3FFF, which is the 16384th counted tick after arming or servicing.
- R5: A complete key sequence while armed resets the count to zero and leaves the watchdog armed.
- R6: On expiry `rst_pulse_o` goes high in the next cycle and stays high for exactly 98 clock cycles.
- R7: `armed_o` falls at the same edge as the pulse ends, and the counter is cleared. Writes made during the pulse are ignored, and the watchdog can be armed again afterwards.
- R8: With `rso_dis_i` high, `rst_pulse_o` stays 0 during expiry, while disarming still happens after 98 cycles.
- R9: While `pdown_i` is high the counter holds its value.
- R10: After `pdown_i` falls while `wake_n_i` is low, the counter holds until `wake_n_i` is high.
- R11: In idle (`idle_i` high) the counter runs when `idle_pause_i` is 0 and holds when it is 1. It resumes when idle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| tick_i | input | 1 | Machine-cycle enable |
| wr_en_i | input | 1 | Write strobe for the key register |
| wr_data_i | input | 8 | Key byte |
| idle_i | input | 1 | CPU is in idle |
| idle_pause_i | input | 1 | 1: hold the count during idle |
| pdown_i | input | 1 | Power-down is active |
| wake_n_i | input | 1 | Wake interrupt level, active low |
| rso_dis_i | input | 1 | 1: mask the reset pulse output |
| rst_pulse_o | output | 1 | Reset pulse on expiry |
| armed_o | output | 1 | Watchdog is armed |

## Verification
The bench measures every expiry to the exact tick. A counter that runs unarmed, skips a paused stretch or ignores a service write then shows up as a pulse one or more ticks too early or too late. The key sequences are driven as a list of broken byte pairs. A detector that accepted 0xE1 without a pending 0x1E, or that kept the pending state across a wrong byte, would arm when it should not.

The pulse is timed edge by edge, with key writes made in the middle of it. A pulse that is one cycle short or long would be caught, and so would a design that rearms during expiry or stays armed after it. The wake case covers power-down left while the interrupt is still low: resuming at the falling edge of power-down would give an early expiry. Both idle options run in the same armed period, so a pause bit that is ignored, or that pauses outside idle, changes the expiry tick.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_A_DEF = 8'h1E;
    localparam logic [7:0] KEY_B_DEF = 8'hE1;

    typedef enum logic {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_st_e;

    typedef struct packed {
        key_st_e st;
    } key_state_t;

    typedef struct packed {
        logic wake_wait;
    } gate_state_t;

endpackage

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = KEY_A_DEF,
    parameter logic [DATA_W-1:0] KEY_SECOND = KEY_B_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              lock_i,
    output logic              key_ok_o
);

    key_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        key_ok_o = 1'b0;
        if (lock_i) begin
            s_d.st = KEY_IDLE;
        end else if (wr_en_i) begin
            if (wr_data_i == KEY_FIRST) begin
                s_d.st = KEY_HALF;
            end else begin
                if ((wr_data_i == KEY_SECOND) && (s_q.st == KEY_HALF)) begin
                    key_ok_o = 1'b1;
                end
                s_d.st = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: KEY_IDLE};
        else         s_q <= s_d;
    end

    AST_KEY_ABANDON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !lock_i && (wr_data_i != KEY_FIRST)) |=> (s_q.st == KEY_IDLE)); // R3

    AST_KEY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_ok_o |=> !key_ok_o); // R2

endmodule

// File: rtl/wdg_run_gate.sv
module wdg_run_gate
    import wdg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic idle_i,
    input  logic idle_pause_i,
    input  logic pdown_i,
    input  logic wake_n_i,
    output logic run_ok_o
);

    gate_state_t s_d, s_q;
    logic        idle_hold;
    logic        wake_hold;

    always_comb begin
        s_d = s_q;
        if (pdown_i) begin
            s_d.wake_wait = 1'b1;
        end else if (wake_n_i) begin
            s_d.wake_wait = 1'b0;
        end
        idle_hold = idle_i && idle_pause_i;
        wake_hold = s_q.wake_wait && !wake_n_i;
        run_ok_o  = !pdown_i && !wake_hold && !idle_hold;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{wake_wait: 1'b0};
        else         s_q <= s_d;
    end

    AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(pdown_i) && !pdown_i && !wake_n_i) |-> !run_ok_o); // R10

    AST_IDLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pdown_i && wake_n_i && !idle_pause_i) |-> run_ok_o); // R11

endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
    parameter int CNT_W     = 14,
    parameter int PULSE_LEN = 98
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic run_ok_i,
    input  logic key_ok_i,
    input  logic rso_dis_i,
    output logic armed_o,
    output logic busy_o,
    output logic rst_pulse_o
);

    localparam int               PW         = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP    = '1;
    localparam logic [PW-1:0]    PULSE_INIT = PW'(PULSE_LEN);
    localparam logic [PW-1:0]    PULSE_LAST = PW'(1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    pulse;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        busy;

    always_comb begin
        s_d  = s_q;
        busy = (s_q.pulse != '0);
        if (busy) begin
            s_d.pulse = s_q.pulse - 1'b1;
            if (s_q.pulse == PULSE_LAST) begin
                s_d.armed = 1'b0;
                s_d.cnt   = '0;
            end
        end else if (s_q.armed) begin
            if (key_ok_i) begin
                s_d.cnt = '0;
            end else if (tick_i && run_ok_i) begin
                if (s_q.cnt == CNT_TOP) begin
                    s_d.cnt   = '0;
                    s_d.pulse = PULSE_INIT;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else if (key_ok_i) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end
        armed_o     = s_q.armed;
        busy_o      = busy;
        rst_pulse_o = busy && !rso_dis_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{armed: 1'b0, cnt: '0, pulse: '0};
        else         s_q <= s_d;
    end

    AST_ARM_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.armed) |-> $past(key_ok_i)); // R2

    AST_EXPIRE_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> ($past(s_q.cnt) == CNT_TOP) && $past(tick_i && run_ok_i)); // R4

    AST_DISARM_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.armed) |-> ($past(s_q.pulse) == PULSE_LAST)); // R7

    AST_HOLD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.armed && !busy && !run_ok_i && !key_ok_i) |=> $stable(s_q.cnt)); // R9

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
    import wdg_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter int               CNT_W      = 14,
    parameter int               PULSE_LEN  = 98,
    parameter logic [DATA_W-1:0] KEY_FIRST  = KEY_A_DEF,
    parameter logic [DATA_W-1:0] KEY_SECOND = KEY_B_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              idle_i,
    input  logic              idle_pause_i,
    input  logic              pdown_i,
    input  logic              wake_n_i,
    input  logic              rso_dis_i,
    output logic              rst_pulse_o,
    output logic              armed_o
);

    logic key_ok;
    logic run_ok;
    logic busy;

    wdg_key_fsm #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .lock_i   (busy),
        .key_ok_o (key_ok)
    );

    wdg_run_gate u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .idle_i      (idle_i),
        .idle_pause_i(idle_pause_i),
        .pdown_i     (pdown_i),
        .wake_n_i    (wake_n_i),
        .run_ok_o    (run_ok)
    );

    wdg_core #(
        .CNT_W    (CNT_W),
        .PULSE_LEN(PULSE_LEN)
    ) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_ok_i   (run_ok),
        .key_ok_i   (key_ok),
        .rso_dis_i  (rso_dis_i),
        .armed_o    (armed_o),
        .busy_o     (busy),
        .rst_pulse_o(rst_pulse_o)
    );

    AST_MASKED_PULSE_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rso_dis_i && $rose(busy)) |-> (armed_o && !rst_pulse_o)); // R8

endmodule

// File: tb/seq_watchdog_bench.sv
module seq_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       idle = 1'b0;
    logic       idle_pause = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_n = 1'b1;
    logic       rso_dis = 1'b0;
    logic       rst_pulse;
    logic       armed;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seq_watchdog u_seq_watchdog (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .idle_i      (idle),
        .idle_pause_i(idle_pause),
        .pdown_i     (pdown),
        .wake_n_i    (wake_n),
        .rso_dis_i   (rso_dis),
        .rst_pulse_o (rst_pulse),
        .armed_o     (armed)
    );

    // {first byte, second byte, armed expected afterwards}
    localparam logic [16:0] KEY_VEC [8] = '{
        {8'h1E, 8'hE1, 1'b1},
        {8'hE1, 8'h1E, 1'b0},
        {8'h1E, 8'h1F, 1'b0},
        {8'h1E, 8'h1E, 1'b0},
        {8'h00, 8'hE1, 1'b0},
        {8'hE1, 8'hE1, 1'b0},
        {8'h1E, 8'hE0, 1'b0},
        {8'h1F, 8'hE1, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        wr(8'h1E);
        wr(8'hE1);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 armed after reset", armed, 1'b0);
        chk("R1 pulse after reset", rst_pulse, 1'b0);
        run(16500);
        chk("R1 no expiry unarmed", rst_pulse, 1'b0);
        chk("R1 stays unarmed", armed, 1'b0);

        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(KEY_VEC[i][16:9]);
            chk("R2/R3 first byte alone", armed, 1'b0);
            wr(KEY_VEC[i][8:1]);
            chk("R2/R3 key pair", armed, KEY_VEC[i][0]);
        end

        // R2 gap between bytes, then R4/R6/R7 expiry timing
        do_reset();
        wr(8'h1E);
        wait_cyc(3);
        wr(8'hE1);
        chk("R2 arm with gap", armed, 1'b1);
        run(16383);
        chk("R4 no expiry at 16383 ticks", rst_pulse, 1'b0);
        run(1);
        chk("R6 pulse starts", rst_pulse, 1'b1);
        chk("R7 armed during pulse", armed, 1'b1);
        arm();
        wait_cyc(95);
        chk("R6 pulse cycle 98", rst_pulse, 1'b1);
        wait_cyc(1);
        chk("R6 pulse ended", rst_pulse, 1'b0);
        chk("R7 disarmed at end, writes ignored", armed, 1'b0);
        arm();
        chk("R7 rearm after pulse", armed, 1'b1);

        // R5 service
        do_reset();
        arm();
        run(10000);
        arm();
        chk("R5 still armed after service", armed, 1'b1);
        run(16383);
        chk("R5 no expiry after service", rst_pulse, 1'b0);
        run(1);
        chk("R5 expiry counted from service", rst_pulse, 1'b1);
        wait_cyc(98);

        // R3 broken sequences while armed do not clear
        do_reset();
        arm();
        run(10000);
        wr(8'h1E);
        wr(8'h55);
        wr(8'hE1);
        wr(8'hE1);
        run(6383);
        chk("R3 no clear, not yet expired", rst_pulse, 1'b0);
        run(1);
        chk("R3 no clear, expiry on time", rst_pulse, 1'b1);
        wait_cyc(98);

        // R8 masked pulse
        do_reset();
        rso_dis = 1'b1;
        arm();
        run(16384);
        chk("R8 pulse masked", rst_pulse, 1'b0);
        chk("R8 armed during masked pulse", armed, 1'b1);
        wait_cyc(97);
        chk("R8 armed before end", armed, 1'b1);
        wait_cyc(1);
        chk("R8 disarmed after 98", armed, 1'b0);
        rso_dis = 1'b0;

        // R9/R10 power-down and wake hold
        do_reset();
        arm();
        run(5000);
        pdown  = 1'b1;
        wake_n = 1'b0;
        run(3000);
        pdown = 1'b0;
        run(2000);
        wake_n = 1'b1;
        run(11383);
        chk("R10 held until wake high", rst_pulse, 1'b0);
        run(1);
        chk("R9 power-down held count", rst_pulse, 1'b1);
        wait_cyc(98);

        // R11 idle with both options
        do_reset();
        arm();
        idle       = 1'b1;
        idle_pause = 1'b0;
        run(4000);
        idle_pause = 1'b1;
        run(3000);
        idle = 1'b0;
        run(12383);
        chk("R11 idle pause held", rst_pulse, 1'b0);
        run(1);
        chk("R11 idle counting and resume", rst_pulse, 1'b1);
        wait_cyc(98);
        idle_pause = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule